// File: doc/BRIEF.md
# Terminal I/O and Interrupt Controller

This block sits next to the instruction sequencer of a small accumulator machine with 16-bit instruction words. It owns the terminal's receive and transmit character registers and their ready flags. It also owns the interrupt enable and the interrupt-pending bit. It receives the timing step from the sequence counter and the instruction word, and it answers with one-cycle control strobes. These strobes load the accumulator's low byte, skip the next instruction, clear the sequence counter, and run the three steps of the interrupt cycle.

On the device side there is a parallel handshake. A keyboard-side agent pulses a strobe to deposit a character. This is accepted only while the receive flag is clear. A printer-side agent pulses an acknowledge to take the pending output character. This is accepted only while the transmit flag is clear.

The interrupt mechanism works in hardware. When interrupts are enabled and either flag is set, the pending bit is set during any step from 3 upward. The next instruction fetch is then replaced by a cycle with three steps:
- Step 0 zeroes the address register and copies the program counter into a scratch register.
- Step 1 writes that scratch value to address 0 and zeroes the program counter.
- Step 2 increments the program counter to 1, drops the enable, and clears the pending bit.

The service routine returns with an indirect branch through address 0.

Top module: `term_io_irq`

## Requirements
- R1: After reset the receive flag is 0, the transmit flag is 1, the interrupt enable and the pending bit are 0, and both character registers hold 0.
- R2: A `dev_in_valid` pulse while the receive flag is 0 stores `dev_in_data` and sets the flag. The same pulse while the flag is 1 is ignored, and the stored character (seen on `acc_data`) is unchanged.
- R3: A `dev_out_ack` pulse while the transmit flag is 0 sets that flag. The same pulse while the flag is 1 has no effect.
- R4: An I/O instruction is recognised only when `step` equals 3 and `instr[15:12]` is 4'hF. Its actions are selected by single bits: bit 11 input, bit 10 output, bit 9 skip-on-input, bit 8 skip-on-output, bit 7 enable, bit 6 disable. Several selected bits act together, and `sc_clear` is raised in that cycle. Any other opcode or step produces none of these actions.
- R5: The input action raises `acc_load` with `acc_data` equal to the received character, and clears the receive flag. A device deposit accepted in the same cycle wins: the new character is stored and the flag ends at 1.
- R6: The output action copies `acc_low` to `dev_out_data` and clears the transmit flag. It takes precedence over a same-cycle acknowledge.
- R7: `pc_skip` is raised in the execute cycle when skip-on-input is selected with the receive flag at 1, or skip-on-output is selected with the transmit flag at 1.
- R8: The enable action sets `int_en` and the disable action clears it. When both are selected, disable wins.
- R9: When `step` is 3 or more, `int_en` is 1 and either flag is 1, `irq_cycle` becomes 1 on the next edge. `fetch_en` is its inverse.
- R10: While `irq_cycle` is 1, `isr_save`, `isr_write` and `isr_vector` are raised at steps 0, 1 and 2 respectively. `sc_clear` is also raised at step 2. After step 2, `irq_cycle` and `int_en` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | STEP_W | Current timing step from the sequence counter |
| instr | input | IR_W | Instruction register contents |
| acc_low | input | CHAR_W | Accumulator low byte |
| dev_in_valid | input | 1 | Device deposits a character (one-cycle pulse) |
| dev_in_data | input | CHAR_W | Character from the device |
| dev_out_ack | input | 1 | Device has taken the output character (one-cycle pulse) |
| dev_out_data | output | CHAR_W | Output character register |
| in_flag | output | 1 | Receive flag: a character is waiting |
| out_flag | output | 1 | Transmit flag: the output register is free |
| int_en | output | 1 | Interrupt enable |
| irq_cycle | output | 1 | Interrupt cycle pending or in progress |
| fetch_en | output | 1 | Normal fetch steps permitted |
| acc_load | output | 1 | Load accumulator low byte from `acc_data` |
| acc_data | output | CHAR_W | Received character register |
| pc_skip | output | 1 | Increment the program counter (skip) |
| sc_clear | output | 1 | Clear the sequence counter |
| isr_save | output | 1 | Interrupt step 0: zero address, copy PC to scratch |
| isr_write | output | 1 | Interrupt step 1: write scratch to address 0, zero PC |
| isr_vector | output | 1 | Interrupt step 2: increment PC |

## Verification
The bench drives repeated deposit strobes and acknowledges while the matching flag already blocks them. A design that overwrote the receive register or re-raised a flag there would corrupt a character the program has not yet read. It also makes the input action coincide with an accepted deposit, and the output action coincide with an acknowledge. A wrong priority here loses a character or reports the transmitter free too early. The enable and disable actions are issued together to catch the wrong winner. The pending bit is provoked both by a flag that rises late in an instruction and by an enable that lands while a flag is already up. A design that set it during steps 0 to 2, or never cleared the enable in the vector step, would re-enter the interrupt cycle endlessly.

// File: rtl/term_io_irq.sv
module term_io_irq #(
  parameter int CHAR_W = 8,
  parameter int STEP_W = 4,
  parameter int IR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic [IR_W-1:0]   instr,
  input  logic [CHAR_W-1:0] acc_low,
  input  logic              dev_in_valid,
  input  logic [CHAR_W-1:0] dev_in_data,
  input  logic              dev_out_ack,
  output logic [CHAR_W-1:0] dev_out_data,
  output logic              in_flag,
  output logic              out_flag,
  output logic              int_en,
  output logic              irq_cycle,
  output logic              fetch_en,
  output logic              acc_load,
  output logic [CHAR_W-1:0] acc_data,
  output logic              pc_skip,
  output logic              sc_clear,
  output logic              isr_save,
  output logic              isr_write,
  output logic              isr_vector
);

  localparam logic [3:0] IO_OPC = 4'hF;
  localparam int B_INP = IR_W - 5;
  localparam int B_OUT = IR_W - 6;
  localparam int B_SKI = IR_W - 7;
  localparam int B_SKO = IR_W - 8;
  localparam int B_ION = IR_W - 9;
  localparam int B_IOF = IR_W - 10;
  localparam logic [STEP_W-1:0] EXEC_STEP = STEP_W'(3);

  logic [CHAR_W-1:0] rx_q, tx_q;
  logic rxf_q, txf_q, ien_q, pend_q;
  logic io_hit, do_inp, do_out, do_ion, do_iof;
  logic dev_load, dev_take, late_step;

  assign io_hit   = (step == EXEC_STEP) && (instr[IR_W-1 -: 4] == IO_OPC);
  assign do_inp   = io_hit & instr[B_INP];
  assign do_out   = io_hit & instr[B_OUT];
  assign do_ion   = io_hit & instr[B_ION];
  assign do_iof   = io_hit & instr[B_IOF];
  assign dev_load = dev_in_valid & ~rxf_q;
  assign dev_take = dev_out_ack & ~txf_q;
  assign late_step = step >= EXEC_STEP;

  assign isr_save   = pend_q && (step == STEP_W'(0));
  assign isr_write  = pend_q && (step == STEP_W'(1));
  assign isr_vector = pend_q && (step == STEP_W'(2));

  assign acc_load = do_inp;
  assign acc_data = rx_q;
  assign pc_skip  = io_hit & ((instr[B_SKI] & rxf_q) | (instr[B_SKO] & txf_q));
  assign sc_clear = io_hit | isr_vector;

  assign dev_out_data = tx_q;
  assign in_flag      = rxf_q;
  assign out_flag     = txf_q;
  assign int_en       = ien_q;
  assign irq_cycle    = pend_q;
  assign fetch_en     = ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      rxf_q <= 1'b0;
    end else if (dev_load) begin
      rx_q  <= dev_in_data;
      rxf_q <= 1'b1;
    end else if (do_inp) begin
      rxf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      txf_q <= 1'b1;
    end else if (do_out) begin
      tx_q  <= acc_low;
      txf_q <= 1'b0;
    end else if (dev_take) begin
      txf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ien_q <= 1'b0;
    else if (isr_vector || do_iof) ien_q <= 1'b0;
    else if (do_ion)           ien_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (isr_vector) pend_q <= 1'b0;
    else if (late_step && ien_q && (rxf_q || txf_q)) pend_q <= 1'b1;
  end

endmodule

// File: rtl/term_io_irq_chk.sv
module term_io_irq_chk #(
  parameter int CHAR_W = 8,
  parameter int STEP_W = 4,
  parameter int IR_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STEP_W-1:0] step,
  input logic [IR_W-1:0]   instr,
  input logic [CHAR_W-1:0] acc_low,
  input logic              dev_in_valid,
  input logic              dev_out_ack,
  input logic [CHAR_W-1:0] dev_out_data,
  input logic              in_flag,
  input logic              out_flag,
  input logic              int_en,
  input logic              irq_cycle,
  input logic [CHAR_W-1:0] acc_data,
  input logic              pc_skip,
  input logic              isr_vector
);

  logic io_now;
  assign io_now = (step == STEP_W'(3)) && (instr[IR_W-1 -: 4] == 4'hF);

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_flag && !in_flag && !int_en && !irq_cycle));

  a_r2_blocked_deposit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flag && dev_in_valid) |=> (acc_data == $past(acc_data)));

  a_r3_take_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_flag && dev_out_ack && !(io_now && instr[IR_W-6])) |=> out_flag);

  a_r6_out_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (io_now && instr[IR_W-6]) |=> (!out_flag && dev_out_data == $past(acc_low)));

  a_r7_skip_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pc_skip |-> (io_now && (in_flag || out_flag)));

  a_r9_pending_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_cycle && step >= STEP_W'(3) && int_en && (in_flag || out_flag)) |=> irq_cycle);

  a_r10_vector_clears: assert property (@(posedge clk) disable iff (!rst_n)
    isr_vector |=> (!irq_cycle && !int_en));

endmodule

bind term_io_irq term_io_irq_chk #(.CHAR_W(CHAR_W), .STEP_W(STEP_W), .IR_W(IR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .instr(instr), .acc_low(acc_low),
  .dev_in_valid(dev_in_valid), .dev_out_ack(dev_out_ack), .dev_out_data(dev_out_data),
  .in_flag(in_flag), .out_flag(out_flag), .int_en(int_en), .irq_cycle(irq_cycle),
  .acc_data(acc_data), .pc_skip(pc_skip), .isr_vector(isr_vector)
);

// File: tb/tb_term_io_irq.sv
module tb_term_io_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] step = '0;
  logic [15:0] instr = '0;
  logic [7:0] acc_low = '0;
  logic dev_in_valid = 1'b0;
  logic [7:0] dev_in_data = '0;
  logic dev_out_ack = 1'b0;
  logic [7:0] dev_out_data, acc_data;
  logic in_flag, out_flag, int_en, irq_cycle, fetch_en, acc_load;
  logic pc_skip, sc_clear, isr_save, isr_write, isr_vector;

  int checks = 0;
  int errors = 0;

  int  m_rx = 0, m_tx = 0;
  bit  m_rxf = 0, m_txf = 1, m_ien = 0, m_pend = 0;

  always #2 clk = ~clk;

  term_io_irq dut (
    .clk(clk), .rst_n(rst_n), .step(step), .instr(instr), .acc_low(acc_low),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_out_ack(dev_out_ack),
    .dev_out_data(dev_out_data), .in_flag(in_flag), .out_flag(out_flag), .int_en(int_en),
    .irq_cycle(irq_cycle), .fetch_en(fetch_en), .acc_load(acc_load), .acc_data(acc_data),
    .pc_skip(pc_skip), .sc_clear(sc_clear), .isr_save(isr_save), .isr_write(isr_write),
    .isr_vector(isr_vector)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int st, input logic [15:0] ir, input logic [7:0] acc,
                      input bit dv, input logic [7:0] dd, input bit da);
    bit hit, e_load, e_skip, e_vec, e_sc;
    bit ld, tk;
    step = st[3:0]; instr = ir; acc_low = acc;
    dev_in_valid = dv; dev_in_data = dd; dev_out_ack = da;
    #1;
    hit    = (st == 3) && (ir[15:12] == 4'hF);
    e_load = hit && ir[11];
    e_skip = hit && ((ir[9] && m_rxf) || (ir[8] && m_txf));
    e_vec  = m_pend && st == 2;
    e_sc   = hit || e_vec;
    chk("R2 in_flag", in_flag, m_rxf);
    chk("R3 out_flag", out_flag, m_txf);
    chk("R6 dev_out_data", dev_out_data, m_tx);
    chk("R5 acc_data", acc_data, m_rx);
    chk("R5 acc_load", acc_load, e_load);
    chk("R7 pc_skip", pc_skip, e_skip);
    chk("R4 sc_clear", sc_clear, e_sc);
    chk("R8 int_en", int_en, m_ien);
    chk("R9 irq_cycle", irq_cycle, m_pend);
    chk("R9 fetch_en", fetch_en, !m_pend);
    chk("R10 isr_save", isr_save, m_pend && st == 0);
    chk("R10 isr_write", isr_write, m_pend && st == 1);
    chk("R10 isr_vector", isr_vector, e_vec);
    ld = dv && !m_rxf;
    tk = da && !m_txf;
    if (m_pend && st == 2) m_pend = 0;
    else if (st >= 3 && m_ien && (m_rxf || m_txf)) m_pend = 1;
    if (e_vec || (hit && ir[6])) m_ien = 0;
    else if (hit && ir[7]) m_ien = 1;
    if (ld) begin m_rx = dd; m_rxf = 1; end
    else if (e_load) m_rxf = 0;
    if (hit && ir[10]) begin m_tx = acc; m_txf = 0; end
    else if (tk) m_txf = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input bit dv, input logic [7:0] dd, input bit da);
    tick(4, 16'h2000, 8'h00, dv, dd, da);
  endtask

  task automatic run_isr();
    for (int s = 0; s < 3; s++) tick(s, 16'h0000, 8'h00, 0, 8'h00, 0);
  endtask

  task automatic run_io(input logic [15:0] w, input logic [7:0] acc,
                        input bit dv, input logic [7:0] dd, input bit da);
    if (m_pend) run_isr();
    for (int s = 0; s < 3; s++) tick(s, w, acc, 0, 8'h00, 0);
    tick(3, w, acc, dv, dd, da);
  endtask

  task automatic run_mem();
    if (m_pend) run_isr();
    for (int s = 0; s < 6; s++) tick(s, 16'h2000, 8'h00, 0, 8'h00, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in_flag", in_flag, 0);
    chk("R1 out_flag", out_flag, 1);
    chk("R1 int_en", int_en, 0);
    chk("R1 irq_cycle", irq_cycle, 0);
    chk("R1 acc_data", acc_data, 0);
    chk("R1 dev_out_data", dev_out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    idle(1, 8'h41, 0);
    idle(1, 8'h55, 0);
    chk("R2 blocked deposit keeps char", acc_data, 8'h41);
    run_io(16'hF200, 8'h00, 0, 8'h00, 0);
    run_io(16'hF100, 8'h00, 0, 8'h00, 0);
    run_io(16'hF800, 8'h00, 0, 8'h00, 0);
    chk("R5 input clears flag", in_flag, 0);
    run_io(16'hF400, 8'h5A, 0, 8'h00, 0);
    chk("R6 output char", dev_out_data, 8'h5A);
    chk("R6 output clears flag", out_flag, 0);
    run_io(16'hF100, 8'h00, 0, 8'h00, 0);
    idle(0, 8'h00, 1);
    chk("R3 take sets flag", out_flag, 1);
    idle(0, 8'h00, 1);
    chk("R3 extra take ignored", out_flag, 1);
    run_io(16'h7800, 8'h00, 0, 8'h00, 0);
    run_io(16'hF400, 8'h33, 0, 8'h00, 0);
    run_io(16'hF400, 8'h77, 0, 8'h00, 1);
    chk("R6 output beats take", out_flag, 0);
    chk("R6 newest char", dev_out_data, 8'h77);
    run_io(16'hF080, 8'h00, 0, 8'h00, 0);
    chk("R8 enable", int_en, 1);
    run_mem();
    chk("R9 no flags no pending", irq_cycle, 0);
    idle(1, 8'h10, 0);
    idle(0, 8'h00, 0);
    chk("R9 pending after deposit", irq_cycle, 1);
    run_isr();
    chk("R10 pending cleared", irq_cycle, 0);
    chk("R10 enable cleared", int_en, 0);
    run_io(16'hF0C0, 8'h00, 0, 8'h00, 0);
    chk("R8 disable wins", int_en, 0);
    run_io(16'hF800, 8'h00, 0, 8'h00, 0);
    run_io(16'hF800, 8'h00, 1, 8'h99, 0);
    chk("R5 deposit beats input flag", in_flag, 1);
    chk("R5 deposit beats input char", acc_data, 8'h99);
    run_io(16'hF080, 8'h00, 0, 8'h00, 0);
    run_mem();
    chk("R9 pending after enable", irq_cycle, 1);
    run_mem();
    chk("R10 serviced", irq_cycle, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule